// File: doc/BRIEF.md
# Completion-versus-Posted Ordering Gate

This block sits between a queue of outgoing completions and a record of posted requests that are still in flight. It decides, for the completion at the head of its queue, whether that completion may be released now or must wait. A completion normally waits until every posted request that was accepted before it has retired. There are three exceptions. A completion marked relaxed-ordering is released at once. So is a completion for an I/O or configuration write. A completion marked ID-based-ordering waits only while an earlier pending posted request carries a requester ID equal to the completion's completer ID.

Posted requests come in on a valid/ready stream (`p_valid`/`p_ready`). `p_ready` is low only when the posted record is full, and it does not look at `p_valid`. The oldest record entry is dropped on a single-cycle `p_retire` pulse. Completions come in on a second valid/ready stream (`c_valid`/`c_ready`). `c_ready` is low only when the completion queue is full. Completions leave on the `rel_valid`/`rel_ready` stream. Once `rel_valid` is raised it stays high, with `rel_tag` unchanged, until `rel_ready` takes the completion. No data moves through the block; it only carries a tag for each completion.

Each queued completion keeps a count of the posted entries that are older than it. The count is taken when the completion is accepted and goes down by one on every retire. A posted request accepted in the same cycle as a completion, or in any later cycle, is not counted against that completion.

Top module: `cpl_order_gate`

## Requirements
- R1: When no attribute bit is set, a completion at the head of the queue holds `rel_valid` low while any posted request accepted before it is still pending.
- R2: A completion with `c_ro` set is released regardless of pending posted requests.
- R3: A completion with `c_iocfg` set (an I/O or configuration write completion) is released regardless of pending posted requests. `c_ro` and `c_iocfg` both take precedence over `c_ido`.
- R4: A completion with only `c_ido` set is held exactly while some earlier pending posted request has a requester ID equal to its `c_cpl_id`.
- R5: A posted request accepted in the same cycle as a completion, or in any later cycle, never holds that completion.
- R6: Completions leave in acceptance order, and a held head blocks the completions behind it. While `rel_valid` is high and `rel_ready` is low, `rel_valid` stays high and `rel_tag` stays stable.
- R7: The posted record holds `P_DEPTH` entries and `p_ready` is low when it is full. `p_retire` removes the oldest entry, and a `p_retire` pulse while the record is empty has no effect.
- R8: The completion queue holds `C_DEPTH` entries and `c_ready` is low when it is full.
- R9: After reset, both records are empty, `p_ready` and `c_ready` are high, and `rel_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| p_valid | input | 1 | Posted request offered |
| p_ready | output | 1 | Posted record has room |
| p_req_id | input | ID_W | Requester ID of the offered posted request |
| p_retire | input | 1 | Pulse: oldest posted request has completed |
| c_valid | input | 1 | Completion offered |
| c_ready | output | 1 | Completion queue has room |
| c_ro | input | 1 | Relaxed-ordering attribute |
| c_ido | input | 1 | ID-based-ordering attribute |
| c_iocfg | input | 1 | Completion of an I/O or configuration write |
| c_cpl_id | input | ID_W | Completer ID of the offered completion |
| c_tag | input | TAG_W | Caller's label for the completion |
| rel_valid | output | 1 | Head completion may be released |
| rel_ready | input | 1 | Consumer takes the released completion |
| rel_tag | output | TAG_W | Label of the head completion |

## Verification
The hardest case to reach is an ID-based-ordering completion whose single matching posted entry sits at some inner position of the record. Reaching it needs the release decision to change at exactly the retire that removes that entry, and at no earlier or later retire. The bench sweeps every record fill from empty to full, every attribute combination, and every position of the matching entry, including no match. It then retires the entries one at a time and predicts `rel_valid` after each retire from the number of entries left and from whether the match is still among them.

// File: rtl/cog_pkg.sv
package cog_pkg;
  typedef struct packed {
    logic ro;
    logic ido;
    logic iocfg;
  } cpl_attr_t;
endpackage

// File: rtl/cog_posted_fifo.sv
module cog_posted_fifo #(
  parameter int DEPTH = 4,
  parameter int ID_W  = 4,
  parameter int CNT_W = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic [ID_W-1:0]            in_id,
  input  logic                       retire_req,
  output logic                       full,
  output logic                       pop,
  output logic [CNT_W-1:0]           cnt,
  output logic [DEPTH-1:0][ID_W-1:0] ids
);
  logic             push;
  logic [CNT_W-1:0] wr_idx;

  assign full   = (cnt == CNT_W'(DEPTH));
  assign push   = in_valid && !full;
  assign pop    = retire_req && (cnt != '0);
  assign wr_idx = pop ? cnt - 1'b1 : cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) ids[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (pop && i < DEPTH - 1) ids[i] <= ids[i+1];
        if (push && wr_idx == CNT_W'(i)) ids[i] <= in_id;
      end
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R7: count bounded, retire removes exactly one entry
  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DEPTH));
  a_r7_retire_one: assert property (@(posedge clk) disable iff (!rst_n)
    pop && !push |=> cnt == $past(cnt) - 1'b1);
endmodule

// File: rtl/cog_cpl_queue.sv
module cog_cpl_queue
  import cog_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int ID_W   = 4,
  parameter int TAG_W  = 4,
  parameter int CNT_W  = 3,
  parameter int ACNT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  cpl_attr_t         in_attr,
  input  logic [ID_W-1:0]   in_id,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic [ACNT_W-1:0] in_ahead,
  input  logic              pop,
  input  logic              p_retired,
  output logic              full,
  output logic [CNT_W-1:0]  cnt,
  output cpl_attr_t         head_attr,
  output logic [ID_W-1:0]   head_id,
  output logic [TAG_W-1:0]  head_tag,
  output logic [ACNT_W-1:0] head_ahead
);
  cpl_attr_t         attr_q  [DEPTH];
  logic [ID_W-1:0]   id_q    [DEPTH];
  logic [TAG_W-1:0]  tag_q   [DEPTH];
  logic [ACNT_W-1:0] ahead_q [DEPTH];
  logic              push;
  logic [CNT_W-1:0]  wr_idx;

  assign full       = (cnt == CNT_W'(DEPTH));
  assign push       = in_valid && !full;
  assign wr_idx     = pop ? cnt - 1'b1 : cnt;
  assign head_attr  = attr_q[0];
  assign head_id    = id_q[0];
  assign head_tag   = tag_q[0];
  assign head_ahead = ahead_q[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        attr_q[i]  <= '0;
        id_q[i]    <= '0;
        tag_q[i]   <= '0;
        ahead_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        logic [ACNT_W-1:0] a_src;
        a_src = (pop && i < DEPTH - 1) ? ahead_q[i+1] : ahead_q[i];
        if (pop && i < DEPTH - 1) begin
          attr_q[i] <= attr_q[i+1];
          id_q[i]   <= id_q[i+1];
          tag_q[i]  <= tag_q[i+1];
        end
        ahead_q[i] <= (p_retired && a_src != '0) ? a_src - 1'b1 : a_src;
        if (push && wr_idx == CNT_W'(i)) begin
          attr_q[i]  <= in_attr;
          id_q[i]    <= in_id;
          tag_q[i]   <= in_tag;
          ahead_q[i] <= in_ahead;
        end
      end
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R8: never accepts beyond capacity, pop only when non-empty
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DEPTH));
  a_r6_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> cnt != '0);
endmodule

// File: rtl/cog_pass_check.sv
module cog_pass_check
  import cog_pkg::*;
#(
  parameter int P_DEPTH = 4,
  parameter int ID_W    = 4,
  parameter int ACNT_W  = 3
) (
  input  logic                         head_valid,
  input  cpl_attr_t                    attr,
  input  logic [ID_W-1:0]              cpl_id,
  input  logic [ACNT_W-1:0]            ahead,
  input  logic [P_DEPTH-1:0][ID_W-1:0] ids,
  output logic                         blocked
);
  logic id_hit;

  always_comb begin
    id_hit = 1'b0;
    for (int k = 0; k < P_DEPTH; k++)
      if (ACNT_W'(k) < ahead && ids[k] == cpl_id) id_hit = 1'b1;
  end

  always_comb begin
    if (!head_valid)                 blocked = 1'b0;
    else if (attr.ro || attr.iocfg)  blocked = 1'b0;
    else if (attr.ido)               blocked = id_hit;
    else                             blocked = (ahead != '0);
  end
endmodule

// File: rtl/cpl_order_gate.sv
module cpl_order_gate
  import cog_pkg::*;
#(
  parameter int P_DEPTH = 4,
  parameter int C_DEPTH = 4,
  parameter int ID_W    = 4,
  parameter int TAG_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             p_valid,
  output logic             p_ready,
  input  logic [ID_W-1:0]  p_req_id,
  input  logic             p_retire,
  input  logic             c_valid,
  output logic             c_ready,
  input  logic             c_ro,
  input  logic             c_ido,
  input  logic             c_iocfg,
  input  logic [ID_W-1:0]  c_cpl_id,
  input  logic [TAG_W-1:0] c_tag,
  output logic             rel_valid,
  input  logic             rel_ready,
  output logic [TAG_W-1:0] rel_tag
);
  localparam int PCNT_W = $clog2(P_DEPTH + 1);
  localparam int CCNT_W = $clog2(C_DEPTH + 1);

  logic                         p_full, p_pop, c_full, blocked, rel_fire;
  logic [PCNT_W-1:0]            p_cnt;
  logic [CCNT_W-1:0]            c_cnt;
  logic [P_DEPTH-1:0][ID_W-1:0] p_ids;
  logic [PCNT_W-1:0]            new_ahead, head_ahead;
  cpl_attr_t                    in_attr, head_attr;
  logic [ID_W-1:0]              head_id;

  assign p_ready   = !p_full;
  assign c_ready   = !c_full;
  assign in_attr   = '{ro: c_ro, ido: c_ido, iocfg: c_iocfg};
  assign new_ahead = p_cnt - PCNT_W'(p_pop);
  assign rel_valid = (c_cnt != '0) && !blocked;
  assign rel_fire  = rel_valid && rel_ready;

  cog_posted_fifo #(.DEPTH(P_DEPTH), .ID_W(ID_W), .CNT_W(PCNT_W)) u_posted (
    .clk, .rst_n, .in_valid(p_valid), .in_id(p_req_id), .retire_req(p_retire),
    .full(p_full), .pop(p_pop), .cnt(p_cnt), .ids(p_ids)
  );

  cog_cpl_queue #(.DEPTH(C_DEPTH), .ID_W(ID_W), .TAG_W(TAG_W),
                  .CNT_W(CCNT_W), .ACNT_W(PCNT_W)) u_cplq (
    .clk, .rst_n, .in_valid(c_valid), .in_attr, .in_id(c_cpl_id), .in_tag(c_tag),
    .in_ahead(new_ahead), .pop(rel_fire), .p_retired(p_pop), .full(c_full),
    .cnt(c_cnt), .head_attr, .head_id, .head_tag(rel_tag), .head_ahead
  );

  cog_pass_check #(.P_DEPTH(P_DEPTH), .ID_W(ID_W), .ACNT_W(PCNT_W)) u_check (
    .head_valid(c_cnt != '0), .attr(head_attr), .cpl_id(head_id),
    .ahead(head_ahead), .ids(p_ids), .blocked
  );

  // R6: an offered release is held steady until taken
  a_r6_release_stable: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid && !rel_ready |=> rel_valid && $stable(rel_tag));
  // R1: a plain completion only leaves once no older posted entry remains
  a_r1_plain_wait: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid && !head_attr.ro && !head_attr.ido && !head_attr.iocfg |-> head_ahead == '0);
  // R5: the older-posted count never exceeds what is actually pending
  a_r5_ahead_bound: assert property (@(posedge clk) disable iff (!rst_n)
    c_cnt != '0 |-> head_ahead <= p_cnt);
  // R9: nothing is released after reset until a completion arrives
  a_r9_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    c_cnt == '0 |-> !rel_valid);
endmodule

// File: tb/cpl_order_gate_bench.sv
`timescale 1ns/1ps
module cpl_order_gate_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic p_valid = 0, p_retire = 0, c_valid = 0, c_ro = 0, c_ido = 0, c_iocfg = 0, rel_ready = 0;
  logic [3:0] p_req_id = 0, c_cpl_id = 0, c_tag = 0;
  logic p_ready, c_ready, rel_valid;
  logic [3:0] rel_tag;
  logic [3:0] tag_ctr = 0;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  cpl_order_gate u_cpl_order_gate (
    .clk, .rst_n, .p_valid, .p_ready, .p_req_id, .p_retire, .c_valid, .c_ready,
    .c_ro, .c_ido, .c_iocfg, .c_cpl_id, .c_tag, .rel_valid, .rel_ready, .rel_tag
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push_p(input logic [3:0] id);
    p_valid = 1; p_req_id = id;
    @(negedge clk); p_valid = 0;
  endtask

  task automatic push_c(input logic ro, input logic ido, input logic io, input logic [3:0] id);
    c_valid = 1; c_ro = ro; c_ido = ido; c_iocfg = io; c_cpl_id = id; c_tag = tag_ctr;
    @(negedge clk); c_valid = 0; tag_ctr++;
  endtask

  task automatic retire();
    p_retire = 1;
    @(negedge clk); p_retire = 0;
  endtask

  task automatic take(input string req, input logic [3:0] exp_tag);
    chk(req, rel_valid, 1);
    chk(req, rel_tag, exp_tag);
    rel_ready = 1;
    @(negedge clk); rel_ready = 0;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [3:0] t0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R9 p_ready", p_ready, 1);
    chk("R9 c_ready", c_ready, 1);
    chk("R9 rel_valid", rel_valid, 0);

    // R1 R2 R3 R4: sweep fill, attributes, matching position, retire steps
    for (int n = 0; n <= 4; n++)
      for (int a = 0; a < 8; a++)
        for (int m = 0; m <= n; m++) begin
          logic ro, ido, io;
          ro = a[0]; ido = a[1]; io = a[2];
          for (int k = 0; k < n; k++) push_p(4'(k + 1));
          t0 = tag_ctr;
          push_c(ro, ido, io, (m < n) ? 4'(m + 1) : 4'd0);
          for (int r = 0; r <= n; r++) begin
            logic hit, exp;
            hit = (m < n) && (m >= r);
            exp = !((n - r) > 0 && !ro && !io && (ido ? hit : 1'b1));
            chk($sformatf("R1_R2_R3_R4 n=%0d attr=%0d m=%0d r=%0d", n, a, m, r), rel_valid, exp);
            if (r < n) retire();
          end
          take("R6 sweep drain", t0);
        end

    // R6: a held plain head blocks a relaxed one behind it; release is stable
    push_p(4'd5);
    t0 = tag_ctr;
    push_c(0, 0, 0, 4'd0);
    push_c(1, 0, 0, 4'd0);
    chk("R6 blocked behind head", rel_valid, 0);
    retire();
    chk("R6 stable valid", rel_valid, 1);
    @(negedge clk);
    chk("R6 stable valid 2", rel_valid, 1);
    chk("R6 stable tag", rel_tag, t0);
    take("R6 first", t0);
    take("R6 second", t0 + 4'd1);

    // R5: posted after completion (later and same cycle) does not hold it
    t0 = tag_ctr;
    push_c(0, 1, 0, 4'd7);
    push_p(4'd7);
    chk("R5 later posted", rel_valid, 1);
    take("R5 drain", t0);
    retire();
    t0 = tag_ctr;
    p_valid = 1; p_req_id = 4'd3;
    c_valid = 1; c_ro = 0; c_ido = 0; c_iocfg = 0; c_tag = tag_ctr;
    @(negedge clk); p_valid = 0; c_valid = 0; tag_ctr++;
    chk("R5 same cycle posted", rel_valid, 1);
    take("R5 drain2", t0);
    retire();

    // R7: full posted record, empty retire ignored, oldest retired first
    for (int k = 0; k < 4; k++) push_p(4'(k + 1));
    chk("R7 full", p_ready, 0);
    retire();
    chk("R7 room after retire", p_ready, 1);
    repeat (3) retire();
    retire();
    t0 = tag_ctr;
    push_c(0, 0, 0, 4'd0);
    chk("R7 empty retire ignored", rel_valid, 1);
    take("R7 drain", t0);
    push_p(4'd1);
    push_p(4'd2);
    retire();
    t0 = tag_ctr;
    push_c(0, 1, 0, 4'd1);
    chk("R7 oldest gone", rel_valid, 1);
    take("R7 drain2", t0);
    t0 = tag_ctr;
    push_c(0, 1, 0, 4'd2);
    chk("R7 newer kept", rel_valid, 0);
    retire();
    take("R7 drain3", t0);

    // R8: completion queue full, then ordered drain
    push_p(4'd9);
    t0 = tag_ctr;
    for (int k = 0; k < 4; k++) push_c(0, 0, 0, 4'd0);
    chk("R8 full", c_ready, 0);
    chk("R8 held", rel_valid, 0);
    retire();
    for (int k = 0; k < 4; k++) take("R6 R8 order", t0 + 4'(k));
    chk("R8 room", c_ready, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule